// File: doc/BRIEF.md
# Multi-Group Capacitive Acquisition Coordinator

This block sits between a register front end and a row of per-group charge-transfer sequencers. Software arms it with a start request. It then launches one acquisition across every analog group at the same moment, either at once or when an external synchronisation input shows the chosen event. While the acquisition runs, it counts the transfer cycles that each enabled group reports and marks each group finished when that group's sampling capacitor crosses its threshold.

The acquisition ends normally once every enabled group is finished. It ends early, with an error, as soon as an unfinished group's counter reaches a coded maximum. Both outcomes raise an end flag, and the early end also raises an error flag. Software clears each flag by writing one to its clear input. A single interrupt line reports any flag whose enable is set.

Top module: `touch_acq_coord`

## Requirements
- R1: With `glb_en`=1, a `start_set` pulse sets `start_bit` at the next edge. In immediate mode (`sync_mode`=0), `run` rises one edge later. At that same edge every group counter becomes 0 and every `grp_stat` bit becomes 0.
- R2: With `sync_mode`=1 the armed block stays idle until the trigger event, and `run` rises at the edge that sees the event. When `sync_pol`=0 the event is a falling edge of `sync_in` (the value sampled at the previous edge is 1 and the present value is 0). When `sync_pol`=1 the event is `sync_in` being high.
- R3: While `run`=1, an enabled group whose status is 0 adds one to its counter at each edge where its `cyc_done` bit is 1. If `thr_hit` is also 1 in that cycle, its status bit is set, and from then on the counter holds its value until the next launch.
- R4: A group whose `grp_en` bit is 0 neither counts nor sets status, and it does not hold back completion. If no group is enabled, the acquisition completes at the first edge of the run.
- R5: At the edge where every enabled group's status is set, `end_flag` is set and both `run` and `start_bit` clear.
- R6: `max_code` values 0 to 6 give limits of 255, 511, 1023, 2047, 4095, 8191 and 16383. Code 7 acts as 16383.
- R7: If an enabled, unfinished group's counter reaches the limit in a cycle where `thr_hit` for that group is 0, the run stops at that edge and both `end_flag` and `err_flag` are set. The status bits of unfinished groups stay 0.
- R8: A `start_clr` pulse cancels the run at the next edge. `run` and `start_bit` both clear, no flag is set, and the counters hold.
- R9: A 1 on `clr_end` or `clr_err` clears that flag at the next edge, and a 0 leaves it unchanged. If a flag is set and cleared in the same cycle, setting wins.
- R10: `irq` is 1 exactly when (`end_flag` and `ie_end`) or (`err_flag` and `ie_err`).
- R11: While `glb_en`=0, `start_set` is ignored and `run` and `start_bit` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable |
| start_set | input | 1 | Software start request pulse |
| start_clr | input | 1 | Software cancel pulse |
| sync_mode | input | 1 | 1: wait for the sync event before launching |
| sync_pol | input | 1 | 0: falling edge; 1: high level |
| sync_in | input | 1 | External synchronisation input |
| max_code | input | 3 | Coded counter limit |
| grp_en | input | NGRP | Group enables |
| ie_end | input | 1 | Interrupt enable for the end flag |
| ie_err | input | 1 | Interrupt enable for the error flag |
| clr_end | input | 1 | Write-one-to-clear for the end flag |
| clr_err | input | 1 | Write-one-to-clear for the error flag |
| cyc_done | input | NGRP | Per-group transfer cycle completed |
| thr_hit | input | NGRP | Per-group threshold reached in this cycle |
| start_bit | output | 1 | Armed or running |
| run | output | 1 | Acquisition running, to the sequencers |
| grp_stat | output | NGRP | Per-group completion status |
| grp_cnt | output | NGRP*CNT_W | Group counters, group g at bits g*CNT_W upward |
| end_flag | output | 1 | End of acquisition flag |
| err_flag | output | 1 | Max-count error flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, each with a distinct wrong behaviour it would expose:
- An all-disabled run must finish at once; a design that waits on disabled groups would hang.
- Counters of finished groups must freeze; a design that let them run on would report inflated counts.
- An error must leave unfinished status bits clear; a design that marked them done would misreport them.
- Reserved code 7 must act as the largest limit; a design that decoded it differently would stop at the wrong count.
- A clear that coincides with a fresh end event must lose to the set; otherwise a completion would be dropped.
- Both sync polarities are exercised, and a cancel must leave the flags untouched and the counts frozen.

// File: rtl/touch_acq_pkg.sv
package touch_acq_pkg;
  localparam int CNT_W_DEF = 14;

  // limit for a 3-bit code: 2^(8+code)-1, reserved code 7 behaves as code 6
  function automatic logic [CNT_W_DEF-1:0] limit_of(input logic [2:0] code);
    logic [2:0] c;
    logic [15:0] v;
    c = (code == 3'd7) ? 3'd6 : code;
    v = (16'd256 << c) - 16'd1;
    return v[CNT_W_DEF-1:0];
  endfunction
endpackage

// File: rtl/acq_trigger.sv
module acq_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic glb_en,
  input  logic start_bit,
  input  logic run,
  input  logic sync_mode,
  input  logic sync_pol,
  input  logic sync_in,
  output logic launch
);
  logic sync_q;
  logic sync_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  assign sync_evt = sync_pol ? sync_in : (sync_q & ~sync_in);
  assign launch   = glb_en & start_bit & ~run & (~sync_mode | sync_evt);

  // R2: in sync mode with falling polarity, a launch needs a 1->0 transition
  a_r2_fall_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && sync_mode && !sync_pol) |-> (sync_q && !sync_in));
endmodule

// File: rtl/acq_group_lane.sv
module acq_group_lane #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             run,
  input  logic             en,
  input  logic             cyc_done,
  input  logic             thr_hit,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             stat,
  output logic             fin_nxt,
  output logic             limit_hit
);
  logic             active;
  logic [CNT_W-1:0] cnt_inc;

  assign active    = run & en & ~stat;
  assign cnt_inc   = cnt + 1'b1;
  assign fin_nxt   = stat | (active & cyc_done & thr_hit);
  assign limit_hit = active & cyc_done & ~thr_hit & (cnt_inc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      stat <= 1'b0;
    end else if (launch) begin
      cnt  <= '0;
      stat <= 1'b0;
    end else if (active && cyc_done) begin
      cnt <= cnt_inc;
      if (thr_hit) stat <= 1'b1;
    end
  end

  a_r1_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (cnt == '0 && !stat));
  a_r3_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !launch) |=> $stable(cnt));
  a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !launch) |=> ($stable(cnt) && $stable(stat)));
endmodule

// File: rtl/acq_flag_unit.sv
module acq_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_end,
  input  logic set_err,
  input  logic clr_end,
  input  logic clr_err,
  input  logic ie_end,
  input  logic ie_err,
  output logic end_flag,
  output logic err_flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_flag <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      end_flag <= set_end | (end_flag & ~clr_end);
      err_flag <= set_err | (err_flag & ~clr_err);
    end
  end

  assign irq = (end_flag & ie_end) | (err_flag & ie_err);

  a_r9_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_end && !set_end) |=> !end_flag);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> err_flag);
  a_r7_err_implies_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> end_flag);
endmodule

// File: rtl/touch_acq_coord.sv
module touch_acq_coord
  import touch_acq_pkg::*;
#(
  parameter int NGRP  = 6,
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glb_en,
  input  logic                  start_set,
  input  logic                  start_clr,
  input  logic                  sync_mode,
  input  logic                  sync_pol,
  input  logic                  sync_in,
  input  logic [2:0]            max_code,
  input  logic [NGRP-1:0]       grp_en,
  input  logic                  ie_end,
  input  logic                  ie_err,
  input  logic                  clr_end,
  input  logic                  clr_err,
  input  logic [NGRP-1:0]       cyc_done,
  input  logic [NGRP-1:0]       thr_hit,
  output logic                  start_bit,
  output logic                  run,
  output logic [NGRP-1:0]       grp_stat,
  output logic [NGRP*CNT_W-1:0] grp_cnt,
  output logic                  end_flag,
  output logic                  err_flag,
  output logic                  irq
);
  logic             launch;
  logic [NGRP-1:0]  fin_nxt;
  logic [NGRP-1:0]  limit_hit;
  logic [CNT_W-1:0] limit;
  logic             done_evt;
  logic             err_evt;
  logic             stop_evt;
  logic             set_end;
  logic             set_err;

  assign limit = CNT_W'(limit_of(max_code));

  acq_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .start_bit(start_bit),
    .run(run), .sync_mode(sync_mode), .sync_pol(sync_pol),
    .sync_in(sync_in), .launch(launch)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_lane
    acq_group_lane #(.CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .launch(launch), .run(run),
      .en(grp_en[g]), .cyc_done(cyc_done[g]), .thr_hit(thr_hit[g]),
      .limit(limit), .cnt(grp_cnt[g*CNT_W +: CNT_W]), .stat(grp_stat[g]),
      .fin_nxt(fin_nxt[g]), .limit_hit(limit_hit[g])
    );
  end

  assign done_evt = run & (&(fin_nxt | ~grp_en));
  assign err_evt  = run & (|limit_hit);
  assign stop_evt = done_evt | err_evt;
  assign set_end  = stop_evt & glb_en & ~start_clr;
  assign set_err  = err_evt & glb_en & ~start_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_bit <= 1'b0;
      run       <= 1'b0;
    end else if (!glb_en || start_clr) begin
      start_bit <= 1'b0;
      run       <= 1'b0;
    end else if (stop_evt) begin
      start_bit <= 1'b0;
      run       <= 1'b0;
    end else begin
      if (start_set) start_bit <= 1'b1;
      if (launch)    run       <= 1'b1;
    end
  end

  acq_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .set_end(set_end), .set_err(set_err),
    .clr_end(clr_end), .clr_err(clr_err), .ie_end(ie_end), .ie_err(ie_err),
    .end_flag(end_flag), .err_flag(err_flag), .irq(irq)
  );

  a_r5_end_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> (!run && !start_bit));
  a_r8_cancel_stops: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr |=> (!run && !start_bit));
  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (!run && !start_bit));
  a_r1_run_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> start_bit);
endmodule

// File: tb/touch_acq_coord_tb.sv
module touch_acq_coord_tb_top;
  localparam int NG = 6;
  localparam int CW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0, start_set = 1'b0, start_clr = 1'b0;
  logic sync_mode = 1'b0, sync_pol = 1'b0, sync_in = 1'b0;
  logic [2:0] max_code = 3'd2;
  logic [NG-1:0] grp_en = '0, cyc_done = '0, thr_hit = '0;
  logic ie_end = 1'b0, ie_err = 1'b0, clr_end = 1'b0, clr_err = 1'b0;
  logic start_bit, run, end_flag, err_flag, irq;
  logic [NG-1:0] grp_stat;
  logic [NG*CW-1:0] grp_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  touch_acq_coord dut_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .start_set(start_set),
    .start_clr(start_clr), .sync_mode(sync_mode), .sync_pol(sync_pol),
    .sync_in(sync_in), .max_code(max_code), .grp_en(grp_en),
    .ie_end(ie_end), .ie_err(ie_err), .clr_end(clr_end), .clr_err(clr_err),
    .cyc_done(cyc_done), .thr_hit(thr_hit), .start_bit(start_bit),
    .run(run), .grp_stat(grp_stat), .grp_cnt(grp_cnt),
    .end_flag(end_flag), .err_flag(err_flag), .irq(irq)
  );

  // enable mask in [53:48]; threshold cycle of group g in [g*8 +: 8]
  localparam logic [53:0] VEC [5] = '{
    {6'b000001, 8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd4},
    {6'b111111, 8'd13, 8'd2,  8'd9,  8'd7,  8'd5,  8'd3},
    {6'b101010, 8'd6,  8'd40, 8'd3,  8'd1,  8'd20, 8'd9},
    {6'b000000, 8'd5,  8'd5,  8'd5,  8'd5,  8'd5,  8'd5},
    {6'b010101, 8'd8,  8'd8,  8'd8,  8'd8,  8'd8,  8'd8}
  };

  function automatic int cnt_of(input int g);
    return int'(grp_cnt[g*CW +: CW]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic arm();
    start_set = 1'b1;
    tick();
    start_set = 1'b0;
  endtask

  // drives cycles; group g reports threshold at cycle thr[g] (0 = never)
  task automatic drive_run(input logic [47:0] thr, input int limit_cycles,
                           input bit clr_at_end, output int used);
    used = 0;
    for (int k = 1; k <= limit_cycles; k++) begin
      cyc_done = '1;
      for (int g = 0; g < NG; g++) thr_hit[g] = (int'(thr[g*8 +: 8]) == k);
      clr_end = clr_at_end;
      tick();
      clr_end = 1'b0;
      used = k;
      if (!run) break;
    end
    cyc_done = '0;
    thr_hit = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int used;
    tick(); tick();
    // reset state
    check("R1 reset run", int'(run), 0);
    check("R1 reset start_bit", int'(start_bit), 0);
    check("R9 reset flags", int'({end_flag, err_flag, irq}), 0);
    rst_n = 1'b1;
    tick();

    // R11: disabled block ignores start
    arm();
    tick(); tick();
    check("R11 start ignored when disabled", int'({start_bit, run}), 0);
    glb_en = 1'b1;
    max_code = 3'd2;

    // table of normal acquisitions
    foreach (VEC[v]) begin
      grp_en = VEC[v][53:48];
      clr_end = 1'b1; clr_err = 1'b1; tick(); clr_end = 1'b0; clr_err = 1'b0;
      arm();
      check("R1 start_bit armed", int'(start_bit), 1);
      tick();
      check("R1 run launched", int'(run), 1);
      for (int g = 0; g < NG; g++) check("R1 counter cleared", cnt_of(g), 0);
      check("R1 status cleared", int'(grp_stat), 0);
      drive_run(VEC[v][47:0], 300, 1'b0, used);
      check("R5 run ended", int'({run, start_bit}), 0);
      check("R5 end flag", int'(end_flag), 1);
      check("R7 no error", int'(err_flag), 0);
      for (int g = 0; g < NG; g++) begin
        if (VEC[v][48+g]) begin
          check("R3 count equals threshold cycle", cnt_of(g), int'(VEC[v][g*8 +: 8]));
          check("R3 status set", int'(grp_stat[g]), 1);
        end else begin
          check("R4 disabled count", cnt_of(g), 0);
          check("R4 disabled status", int'(grp_stat[g]), 0);
        end
      end
      if (VEC[v][53:48] == 6'b000000) check("R4 empty run ends at once", used, 1);
    end

    // R3: counter holds after further cycle pulses with no run
    cyc_done = '1; tick(); tick(); cyc_done = '0;
    check("R3 counter holds", cnt_of(0), 8);

    // R10 irq gating
    ie_end = 1'b0; tick();
    check("R10 irq masked", int'(irq), 0);
    ie_end = 1'b1; tick();
    check("R10 irq end", int'(irq), 1);
    clr_end = 1'b0; tick();
    check("R9 write zero keeps flag", int'(end_flag), 1);
    clr_end = 1'b1; tick(); clr_end = 1'b0;
    check("R9 clear end", int'(end_flag), 0);
    check("R10 irq drops", int'(irq), 0);

    // R9 set wins over simultaneous clear
    grp_en = 6'b000001;
    arm(); tick();
    drive_run({40'd0, 8'd3}, 20, 1'b1, used);
    check("R9 set beats clear", int'(end_flag), 1);
    clr_end = 1'b1; tick(); clr_end = 1'b0;

    // R6/R7 error with code 0 (limit 255)
    max_code = 3'd0;
    grp_en = 6'b000111;
    arm(); tick();
    drive_run({24'd0, 8'd0, 8'd0, 8'd10}, 400, 1'b0, used);
    check("R6 code0 limit cycles", used, 255);
    check("R7 end flag", int'(end_flag), 1);
    check("R7 err flag", int'(err_flag), 1);
    check("R7 run stopped", int'({run, start_bit}), 0);
    check("R7 finished group count", cnt_of(0), 10);
    check("R7 stuck group count", cnt_of(1), 255);
    check("R7 status only finished", int'(grp_stat), 1);
    ie_err = 1'b1; ie_end = 1'b0;
    clr_end = 1'b1; tick(); clr_end = 1'b0;
    check("R10 irq from error", int'(irq), 1);
    clr_err = 1'b1; tick(); clr_err = 1'b0;
    check("R9 clear err", int'({err_flag, irq}), 0);

    // R6 reserved code 7 behaves as 16383
    max_code = 3'd7;
    grp_en = 6'b000001;
    arm(); tick();
    drive_run(48'd0, 17000, 1'b0, used);
    check("R6 code7 limit", used, 16383);
    check("R6 code7 count", cnt_of(0), 16383);
    check("R6 code7 err", int'(err_flag), 1);
    clr_end = 1'b1; clr_err = 1'b1; tick(); clr_end = 1'b0; clr_err = 1'b0;
    max_code = 3'd2;

    // R8 cancel
    arm(); tick();
    drive_run(48'd0, 5, 1'b0, used);
    start_clr = 1'b1; tick(); start_clr = 1'b0;
    check("R8 cancel stops", int'({run, start_bit}), 0);
    check("R8 no flags on cancel", int'({end_flag, err_flag}), 0);
    check("R8 counter holds", cnt_of(0), 5);

    // R2 sync falling edge
    sync_mode = 1'b1; sync_pol = 1'b0; sync_in = 1'b1;
    arm(); tick(); tick(); tick();
    check("R2 waits for falling edge", int'(run), 0);
    sync_in = 1'b0; tick();
    check("R2 falling edge launches", int'(run), 1);
    drive_run({40'd0, 8'd2}, 20, 1'b0, used);
    check("R2 fall run completes", int'(end_flag), 1);
    clr_end = 1'b1; tick(); clr_end = 1'b0;

    // R2 sync high level
    sync_pol = 1'b1; sync_in = 1'b0;
    arm(); tick(); tick();
    check("R2 waits for high", int'(run), 0);
    sync_in = 1'b1; tick();
    check("R2 high launches", int'(run), 1);
    drive_run({40'd0, 8'd2}, 20, 1'b0, used);
    check("R2 high run count", cnt_of(0), 2);

    // R11: dropping global enable during run stops it
    sync_mode = 1'b0; sync_in = 1'b0;
    arm(); tick();
    glb_en = 1'b0; tick();
    check("R11 run cleared by disable", int'({run, start_bit}), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule